// File: doc/BRIEF.md
# Successive-Approximation Delay-Matching Temperature Controller

This block runs a binary search over the tap setting of an adjustable reference delay line. The search drives the reference delay toward the delay of a temperature-dependent sensing line. Each trial sends one edge into both lines. An external time comparator then reports whether the reference edge arrived after the sensing edge. The controller settles one code bit per trial, starting at the most significant bit and ending at the least significant bit. When the search ends, the code it has built is the temperature reading.

A start request first releases the power-down control of the delay cells. The controller then waits a fixed number of clocks so that the compensation bias can settle. After that it issues the launch pulses, one trial at a time. At the end of the conversion it raises the power-down control again, so that the cells draw no quiescent current between conversions. The result and the completion flag are held until the next start. The delay lines and the comparator are outside this block.

Top module: `sar_thermostat_ctrl`

## Requirements
- R1: After reset, `cells_off_o` is 1, `conv_done_o` is 0, `launch_o` is 0 and `tap_code_o` is 0.
- R2: A start request is accepted when the block is idle or done. In the cycle after it is accepted, `cells_off_o` and `conv_done_o` are both 0.
- R3: Suppose a start request is sampled at clock edge k. The first `launch_o` pulse is then high in the cycle that follows edge k+SETTLE_CYC, and not before.
- R4: `launch_o` is a single-cycle pulse. Exactly WIDTH pulses are issued per conversion.
- R5: At each launch, `tap_code_o` holds the decided upper bits, a 1 in the bit under test and 0 in every lower bit.
- R6: The bits are tested in order from bit WIDTH-1 down to bit 0.
- R7: The block samples `cmp_valid_i` only while it waits for a trial result. At that point the bit under test is kept when `ref_late_i` is 1 (the reference edge came after the sensing edge) and cleared when it is 0. A `cmp_valid_i` seen at any other time has no effect.
- R8: In the cycle after the bit 0 decision, `conv_done_o` is 1 and `cells_off_o` is 1, and `tap_code_o` bit i equals the decision made for bit i.
- R9: While `conv_done_o` is 1 and no start is given, `conv_done_o` and `tap_code_o` stay unchanged. A start given during settling or a trial is ignored.
- R10: Assume `ref_late_i` is 1 exactly when the trial code is at most a target value T. The final code is then T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request |
| cmp_valid_i | input | 1 | Comparator result strobe |
| ref_late_i | input | 1 | 1 when the reference edge arrived after the sensing edge |
| tap_code_o | output | WIDTH | Reference delay line tap setting, and the result when done |
| launch_o | output | 1 | Edge launch pulse into both lines |
| conv_done_o | output | 1 | Conversion complete, result valid |
| cells_off_o | output | 1 | Power-down of the delay cell bias |

## Verification
The hardest situations to reach are the stray inputs: a comparator strobe that arrives during the settle wait or after completion, and a new start request given in the middle of a search. If the block reacted to either one, only a small shift in the final code or in the pulse count would show it. To reach them, the stimulus deliberately raises `cmp_valid_i` with a contradicting `ref_late_i` during settling and while done. It also pulses `start_i` inside random trials. It then checks the launch count, the code at each launch and the final code against a search model kept in the bench. The trial responses come from a target-threshold comparator or from random bit patterns, and the strobe delays are random.

// File: rtl/sar_thermo_pkg.sv
package sar_thermo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    // Control word from the sequencer to the trial register
    typedef struct packed {
        logic init;    // clear code, point at MSB
        logic arm;     // set the bit under test for the first trial
        logic decide;  // resolve the bit under test
        logic keep;    // value given to the bit under test on decide
    } trial_ctl_t;

    function automatic logic [31:0] below_mask(input int unsigned pos);
        return (32'd1 << pos) - 32'd1;
    endfunction

endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CW'(SETTLE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the count only advances while the wait is running
    assert_settle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_thermo_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  trial_ctl_t               ctl_i,
    output logic [WIDTH-1:0]         code_o,
    output logic [$clog2(WIDTH)-1:0] ptr_o,
    output logic                     last_o
);
    localparam int unsigned PW = $clog2(WIDTH);

    logic [WIDTH-1:0] code_q;
    logic [PW-1:0]    ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            ptr_q  <= PW'(WIDTH - 1);
        end else if (ctl_i.init) begin
            code_q <= '0;
            ptr_q  <= PW'(WIDTH - 1);
        end else if (ctl_i.arm) begin
            code_q[ptr_q] <= 1'b1;
        end else if (ctl_i.decide) begin
            code_q[ptr_q] <= ctl_i.keep;
            if (ptr_q != '0) begin
                ptr_q             <= ptr_q - 1'b1;
                code_q[ptr_q - 1] <= 1'b1;
            end
        end
    end

    assign code_o = code_q;
    assign ptr_o  = ptr_q;
    assign last_o = (ptr_q == '0);

    // R7: a decision leaves the tested bit equal to the comparator verdict
    assert_decide_bit_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_i.decide |=> code_q[$past(ptr_q)] == $past(ctl_i.keep));

    // R6: after a non-final decision the pointer moves one bit down
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.decide && ptr_q != '0) |=> ptr_q == $past(ptr_q) - 1'b1);

    // R5: the next bit under test is set and all bits below it are clear
    assert_trial_shape_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.arm || (ctl_i.decide && ptr_q != '0)) |=>
            code_q[ptr_q] && ((32'(code_q) & below_mask(32'(ptr_q))) == 32'd0));

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_thermo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cmp_valid_i,
    input  logic       ref_late_i,
    input  logic       settle_done_i,
    input  logic       last_bit_i,
    output trial_ctl_t ctl_o,
    output logic       settle_clr_o,
    output logic       settle_run_o,
    output logic       launch_o,
    output logic       done_o,
    output logic       cells_off_o
);
    seq_state_e state_q, state_d;
    logic       off_q;
    logic       accept;
    logic       decide;

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign decide = (state_q == ST_WAIT) && cmp_valid_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (accept)        state_d = ST_SETTLE;
            ST_SETTLE:        if (settle_done_i) state_d = ST_LAUNCH;
            ST_LAUNCH:                           state_d = ST_WAIT;
            ST_WAIT:          if (decide)        state_d = last_bit_i ? ST_DONE : ST_LAUNCH;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            off_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                off_q <= 1'b0;
            end else if (decide && last_bit_i) begin
                off_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl_o        = '0;
        ctl_o.init   = accept;
        ctl_o.arm    = (state_q == ST_SETTLE) && settle_done_i;
        ctl_o.decide = decide;
        ctl_o.keep   = ref_late_i;
    end

    assign settle_clr_o = accept;
    assign settle_run_o = (state_q == ST_SETTLE);
    assign launch_o     = (state_q == ST_LAUNCH);
    assign done_o       = (state_q == ST_DONE);
    assign cells_off_o  = off_q;

    // R4: launch never lasts more than one cycle
    assert_launch_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        launch_o |=> !launch_o);

    // R8: completion always comes with the cells powered down
    assert_done_off_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cells_off_o);

    // R2: an accepted start powers up the cells and clears done
    assert_start_power_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!cells_off_o && !done_o));

    // R9: done persists until a start request arrives
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R9: a start request during a trial wait does not disturb the wait
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && start_i && !cmp_valid_i) |=> state_q == ST_WAIT);

endmodule

// File: rtl/sar_thermostat_ctrl.sv
module sar_thermostat_ctrl
    import sar_thermo_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_valid_i,
    input  logic             ref_late_i,
    output logic [WIDTH-1:0] tap_code_o,
    output logic             launch_o,
    output logic             conv_done_o,
    output logic             cells_off_o
);
    localparam int unsigned PW = $clog2(WIDTH);

    trial_ctl_t    ctl;
    logic          settle_clr;
    logic          settle_run;
    logic          settle_done;
    logic          last_bit;
    logic [PW-1:0] ptr;

    sar_seq_fsm u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cmp_valid_i  (cmp_valid_i),
        .ref_late_i   (ref_late_i),
        .settle_done_i(settle_done),
        .last_bit_i   (last_bit),
        .ctl_o        (ctl),
        .settle_clr_o (settle_clr),
        .settle_run_o (settle_run),
        .launch_o     (launch_o),
        .done_o       (conv_done_o),
        .cells_off_o  (cells_off_o)
    );

    sar_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (settle_clr),
        .run_i    (settle_run),
        .expired_o(settle_done)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ctl),
        .code_o(tap_code_o),
        .ptr_o (ptr),
        .last_o(last_bit)
    );

    // R5: at launch every bit below the tested one is zero
    assert_launch_code_R5: assert property (@(posedge clk) disable iff (rst)
        launch_o |-> (tap_code_o[ptr] && ((32'(tap_code_o) & below_mask(32'(ptr))) == 32'd0)));

    // R9: the result is frozen while done and no start arrives
    assert_result_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (conv_done_o && !start_i) |=> $stable(tap_code_o));

endmodule

// File: tb/sar_thermostat_ctrl_tb.sv
module sar_thermostat_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int SETTLE     = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic         cmp_valid_i;
    logic         ref_late_i;
    logic [W-1:0] tap_code_o;
    logic         launch_o;
    logic         conv_done_o;
    logic         cells_off_o;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_thermostat_ctrl #(.WIDTH(W), .SETTLE_CYC(SETTLE)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cmp_valid_i(cmp_valid_i),
        .ref_late_i (ref_late_i),
        .tap_code_o (tap_code_o),
        .launch_o   (launch_o),
        .conv_done_o(conv_done_o),
        .cells_off_o(cells_off_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Trial code the bench expects at launch of bit b given decided upper bits
    function automatic logic [W-1:0] trial_code(input logic [W-1:0] decided, input int b);
        logic [W-1:0] m;
        m = ~((W'(1) << (b + 1)) - W'(1));
        return (decided & m) | (W'(1) << b);
    endfunction

    // mode 0: threshold comparator at target; mode 1: scripted verdicts
    function automatic logic verdict(input int mode, input logic [W-1:0] code,
                                     input logic [W-1:0] target, input logic [W-1:0] resp,
                                     input int b);
        if (mode == 0) return code <= target;
        return resp[b];
    endfunction

    function automatic logic [W-1:0] final_expect(input int mode, input logic [W-1:0] target,
                                                  input logic [W-1:0] resp);
        return (mode == 0) ? target : resp;
    endfunction

    task automatic conversion(input int mode, input logic [W-1:0] target,
                              input logic [W-1:0] resp, input bit stray, input bit busy_start);
        logic [W-1:0] decided;
        int           launches;
        int           waited;
        int           busy_bit;
        logic         v;
        decided  = '0;
        launches = 0;
        busy_bit = $urandom_range(0, W - 1);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: cells on and done low right after acceptance
        chk("R2 cells_off", 32'(cells_off_o), 0);
        chk("R2 done", 32'(conv_done_o), 0);
        // R3: launch appears exactly SETTLE cycles after acceptance
        waited = 1;
        while (!launch_o && waited < 50) begin
            if (stray) begin
                cmp_valid_i = 1'b1;
                ref_late_i  = ~verdict(mode, W'(1) << (W - 1), target, resp, W - 1);
            end
            @(negedge clk);
            cmp_valid_i = 1'b0;
            waited++;
        end
        chk("R3 settle cycles", 32'(waited), 32'(SETTLE + 1));
        for (int b = W - 1; b >= 0; b--) begin
            int guard = 0;
            while (!launch_o && guard < 50) begin
                @(negedge clk);
                guard++;
            end
            if (launch_o) launches++;
            // R5 and R6: code at launch follows MSB-first trial shape
            chk("R5 R6 trial code", 32'(tap_code_o), 32'(trial_code(decided, b)));
            v = verdict(mode, tap_code_o, target, resp, b);
            @(negedge clk);
            // R4: single-cycle launch
            chk("R4 launch width", 32'(launch_o), 0);
            if (busy_start && b == busy_bit) start_i = 1'b1;
            for (int d = $urandom_range(0, 2); d > 0; d--) @(negedge clk);
            start_i     = 1'b0;
            cmp_valid_i = 1'b1;
            ref_late_i  = v;
            decided     = trial_code(decided, b);
            decided[b]  = v;
            @(negedge clk);
            cmp_valid_i = 1'b0;
        end
        // R4: count of launches
        chk("R4 launch count", 32'(launches), 32'(W));
        // R8: done, cells off, result right after last decision
        chk("R8 done", 32'(conv_done_o), 1);
        chk("R8 cells_off", 32'(cells_off_o), 1);
        chk("R8 result", 32'(tap_code_o), 32'(decided));
        // R10: threshold comparator yields the target; R7: verdicts taken as given
        if (mode == 0) chk("R10 target", 32'(tap_code_o), 32'(final_expect(mode, target, resp)));
        else           chk("R7 verdict bits", 32'(tap_code_o), 32'(final_expect(mode, target, resp)));
        // R9 and R7: hold with stray strobes after completion
        for (int k = 0; k < 3; k++) begin
            cmp_valid_i = 1'b1;
            ref_late_i  = ~tap_code_o[0];
            @(negedge clk);
            cmp_valid_i = 1'b0;
            chk("R9 R7 hold code", 32'(tap_code_o), 32'(decided));
            chk("R9 hold done", 32'(conv_done_o), 1);
            chk("R9 no launch", 32'(launch_o), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1; start_i = 1'b0; cmp_valid_i = 1'b0; ref_late_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 cells_off", 32'(cells_off_o), 1);
        chk("R1 done", 32'(conv_done_o), 0);
        chk("R1 launch", 32'(launch_o), 0);
        chk("R1 code", 32'(tap_code_o), 0);
        // directed corners
        conversion(0, 8'h00, '0, 1'b0, 1'b0);
        conversion(0, 8'hFF, '0, 1'b1, 1'b0);
        conversion(0, 8'h80, '0, 1'b1, 1'b1);
        conversion(0, 8'h7F, '0, 1'b0, 1'b1);
        conversion(1, '0, 8'h00, 1'b1, 1'b0);
        conversion(1, '0, 8'hFF, 1'b1, 1'b1);
        conversion(1, '0, 8'hA5, 1'b0, 1'b0);
        // random mix
        for (int n = 0; n < 40; n++) begin
            conversion(int'($urandom_range(0, 1)), W'($urandom), W'($urandom),
                       1'($urandom), 1'($urandom));
            for (int g = $urandom_range(0, 3); g > 0; g--) @(negedge clk);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule